// File: doc/BRIEF.md
# Packet PHY Receive Deframer

This block sits behind a demodulator that delivers one 4-bit symbol per valid strobe. It searches the symbol stream for a run of zero-valued preamble symbols and then for the one-octet start delimiter 0xA7. Once locked, it assembles the following symbols into octets, low nibble first. The first octet is a length header and the rest are payload.

The header's low seven bits give the payload octet count. Its top bit is reserved and must be zero. A header with that bit set drops the frame with a format-error pulse. Each payload octet comes out as a one-cycle write into an external receive buffer, at addresses that count up from zero. A frame-complete pulse marks the end of the frame, and the block then returns to the search.

All outputs are registered. Each output reacts in the cycle after the clock edge that consumes the symbol which triggers it. A cycle with the valid strobe low does not advance any state.

Top module: `pktRxDeframer`

## Requirements
- R1: A delimiter is accepted only if at least MIN_ZERO (default 2) consecutive zero symbols were received directly before it; with fewer zeros no frame starts.
- R2: The delimiter 0xA7 is received as symbol 0x7 followed by symbol 0xA. Any symbol other than zero or a correctly placed delimiter nibble restarts the search. frameStart is high for exactly one cycle, in the cycle after the edge that takes the 0xA symbol.
- R3: Octets are formed from symbol pairs: the first symbol is bits 3:0 and the second is bits 7:4.
- R4: After a header with bit 7 clear, frameLen shows header bits 6:0, and exactly that many payload octets are written to the buffer.
- R5: A header with bit 7 set gives a one-cycle fmtErr pulse. There are no buffer writes and no frameDone for that frame, and the search resumes. fmtErr, frameStart and frameDone are never high together.
- R6: A header of length 0 gives frameDone in the cycle after the header's second symbol, with no buffer writes.
- R7: For a nonzero length, frameDone is high in the same cycle as the write of the last payload octet. The next frame can follow directly.
- R8: Payload writes go to bufAddr 0, 1, 2 … in order within a frame, with bufData holding the assembled octet.
- R9: Cycles with symValid low change no state and produce no output pulse, whatever value symData has.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| symValid | input | 1 | Symbol strobe |
| symData | input | 4 | Demodulated symbol |
| frameStart | output | 1 | Pulse: delimiter matched |
| frameLen | output | 7 | Decoded payload length of the current frame |
| bufWe | output | 1 | Buffer write strobe |
| bufAddr | output | 7 | Buffer write address |
| bufData | output | 8 | Buffer write data |
| frameDone | output | 1 | Pulse: all payload octets written |
| fmtErr | output | 1 | Pulse: reserved header bit set, frame dropped |

## Verification
Every payload length from 0 to 127 is sent, each with its own arithmetic byte pattern. This separates nibble-order, address and off-by-one count faults. The preamble length is varied, and some frames have idle gaps between symbols. The gaps show whether progress is held while the strobe is low. Streams with a single zero, a stray symbol before the delimiter, or a wrong second delimiter nibble must not start a frame. A header with the reserved bit set must raise only the error pulse. Frames sent back to back show that the search resumes at once.

// File: rtl/deframePkg.sv
package deframePkg;
  localparam int LEN_W = 7;
  localparam logic [7:0] SFD_VAL = 8'hA7;

  typedef enum logic [2:0] {
    ST_HUNT, ST_SFDHI, ST_HDRLO, ST_HDRHI, ST_PAYLO, ST_PAYHI
  } rxState_t;

  typedef struct packed {
    logic takeLo;
    logic takeLen;
    logic writeByte;
    logic startPulse;
    logic donePulse;
    logic errPulse;
  } rxStrobe_t;
endpackage

// File: rtl/deframeCtrl.sv
module deframeCtrl
  import deframePkg::*;
#(
  parameter int MIN_ZERO = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             symValid,
  input  logic [3:0]       symData,
  input  logic [7:0]       curOctet,
  input  logic [LEN_W-1:0] lenReg,
  input  logic [LEN_W-1:0] wrCnt,
  output rxStrobe_t        strb
);
  localparam int ZC_W = $clog2(MIN_ZERO + 1);

  rxState_t st, stNext;
  logic [ZC_W-1:0] zeroCnt, zcNext;

  always_comb begin
    strb   = '0;
    stNext = st;
    zcNext = zeroCnt;
    if (symValid) begin
      case (st)
        ST_HUNT: begin
          if (symData == 4'd0) begin
            if (zeroCnt != ZC_W'(MIN_ZERO)) zcNext = zeroCnt + 1'b1;
          end else if (symData == SFD_VAL[3:0] && zeroCnt == ZC_W'(MIN_ZERO)) begin
            stNext = ST_SFDHI;
            zcNext = '0;
          end else begin
            zcNext = '0;
          end
        end
        ST_SFDHI: begin
          if (symData == SFD_VAL[7:4]) begin
            stNext = ST_HDRLO;
            strb.startPulse = 1'b1;
          end else begin
            stNext = ST_HUNT;
            zcNext = ZC_W'(symData == 4'd0);
          end
        end
        ST_HDRLO: begin
          strb.takeLo = 1'b1;
          stNext = ST_HDRHI;
        end
        ST_HDRHI: begin
          if (curOctet[7]) begin
            strb.errPulse = 1'b1;
            stNext = ST_HUNT;
          end else begin
            strb.takeLen = 1'b1;
            if (curOctet[LEN_W-1:0] == '0) begin
              strb.donePulse = 1'b1;
              stNext = ST_HUNT;
            end else begin
              stNext = ST_PAYLO;
            end
          end
        end
        ST_PAYLO: begin
          strb.takeLo = 1'b1;
          stNext = ST_PAYHI;
        end
        ST_PAYHI: begin
          strb.writeByte = 1'b1;
          if (wrCnt == lenReg - 1'b1) begin
            strb.donePulse = 1'b1;
            stNext = ST_HUNT;
          end else begin
            stNext = ST_PAYLO;
          end
        end
        default: stNext = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st      <= ST_HUNT;
      zeroCnt <= '0;
    end else begin
      st      <= stNext;
      zeroCnt <= zcNext;
    end
  end
endmodule

// File: rtl/deframeData.sv
module deframeData
  import deframePkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       symData,
  input  rxStrobe_t        strb,
  output logic [7:0]       curOctet,
  output logic [LEN_W-1:0] wrCnt,
  output logic [LEN_W-1:0] frameLen,
  output logic             frameStart,
  output logic             frameDone,
  output logic             fmtErr,
  output logic             bufWe,
  output logic [LEN_W-1:0] bufAddr,
  output logic [7:0]       bufData
);
  logic [3:0] loNib;

  assign curOctet = {symData, loNib};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loNib      <= '0;
      wrCnt      <= '0;
      frameLen   <= '0;
      frameStart <= 1'b0;
      frameDone  <= 1'b0;
      fmtErr     <= 1'b0;
      bufWe      <= 1'b0;
      bufAddr    <= '0;
      bufData    <= '0;
    end else begin
      frameStart <= strb.startPulse;
      frameDone  <= strb.donePulse;
      fmtErr     <= strb.errPulse;
      bufWe      <= strb.writeByte;
      if (strb.takeLo) loNib <= symData;
      if (strb.takeLen) begin
        frameLen <= curOctet[LEN_W-1:0];
        wrCnt    <= '0;
      end
      if (strb.writeByte) begin
        bufAddr <= wrCnt;
        bufData <= curOctet;
        wrCnt   <= wrCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pktRxDeframer.sv
module pktRxDeframer #(
  parameter int MIN_ZERO = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       symValid,
  input  logic [3:0] symData,
  output logic       frameStart,
  output logic [6:0] frameLen,
  output logic       bufWe,
  output logic [6:0] bufAddr,
  output logic [7:0] bufData,
  output logic       frameDone,
  output logic       fmtErr
);
  import deframePkg::*;

  rxStrobe_t        strb;
  logic [7:0]       curOctet;
  logic [LEN_W-1:0] wrCnt;

  deframeCtrl #(.MIN_ZERO(MIN_ZERO)) uCtrl (
    .clk(clk), .rstN(rstN), .symValid(symValid), .symData(symData),
    .curOctet(curOctet), .lenReg(frameLen), .wrCnt(wrCnt), .strb(strb)
  );

  deframeData uData (
    .clk(clk), .rstN(rstN), .symData(symData), .strb(strb),
    .curOctet(curOctet), .wrCnt(wrCnt), .frameLen(frameLen),
    .frameStart(frameStart), .frameDone(frameDone), .fmtErr(fmtErr),
    .bufWe(bufWe), .bufAddr(bufAddr), .bufData(bufData)
  );
endmodule

// File: rtl/deframeCheck.sv
module deframeCheck (
  input logic       clk,
  input logic       rstN,
  input logic       symValid,
  input logic       frameStart,
  input logic [6:0] frameLen,
  input logic       bufWe,
  input logic [6:0] bufAddr,
  input logic       frameDone,
  input logic       fmtErr
);
  logic [6:0] expAddr;

  always_ff @(posedge clk) begin
    if (!rstN)           expAddr <= '0;
    else if (frameStart) expAddr <= '0;
    else if (bufWe)      expAddr <= expAddr + 1'b1;
  end

  a_r8_addr_in_order: assert property (@(posedge clk) disable iff (!rstN)
    bufWe |-> bufAddr == expAddr);

  a_r4_addr_below_len: assert property (@(posedge clk) disable iff (!rstN)
    bufWe |-> bufAddr < frameLen);

  a_r7_done_on_last_write: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && frameLen != 7'd0) |-> bufWe);

  a_r5_err_quiet: assert property (@(posedge clk) disable iff (!rstN)
    fmtErr |-> (!bufWe && !frameDone));

  a_r5_pulses_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({frameStart, frameDone, fmtErr}));

  a_r9_idle_no_pulse: assert property (@(posedge clk) disable iff (!rstN)
    !$past(symValid) |-> !(bufWe || frameStart || frameDone || fmtErr));
endmodule

bind pktRxDeframer deframeCheck uChk (
  .clk(clk), .rstN(rstN), .symValid(symValid), .frameStart(frameStart),
  .frameLen(frameLen), .bufWe(bufWe), .bufAddr(bufAddr),
  .frameDone(frameDone), .fmtErr(fmtErr)
);

// File: tb/sim_pktRxDeframer.sv
`timescale 1ns/1ps
module sim_pktRxDeframer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic symValid = 1'b0;
  logic [3:0] symData = 4'd0;
  logic frameStart, bufWe, frameDone, fmtErr;
  logic [6:0] frameLen, bufAddr;
  logic [7:0] bufData;

  int errors = 0;
  int checks = 0;
  int nStart = 0, nDone = 0, nErr = 0, nWr = 0;
  logic [7:0] mem [0:127];
  bit finished = 0;

  always #2.5 clk = ~clk;

  pktRxDeframer u0 (
    .clk(clk), .rstN(rstN), .symValid(symValid), .symData(symData),
    .frameStart(frameStart), .frameLen(frameLen), .bufWe(bufWe),
    .bufAddr(bufAddr), .bufData(bufData), .frameDone(frameDone), .fmtErr(fmtErr)
  );

  always @(posedge clk) begin
    if (rstN) begin
      if (frameStart) nStart++;
      if (frameDone)  nDone++;
      if (fmtErr)     nErr++;
      if (bufWe) begin
        nWr++;
        mem[bufAddr] = bufData;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int len, input int i);
    return 8'((len * 3 + i * 29 + 5) & 255);
  endfunction

  task automatic sendSym(input logic [3:0] v, input bit gap);
    if (gap) begin
      @(negedge clk);
      symValid = 1'b0;
      symData  = 4'h5;
    end
    @(negedge clk);
    symValid = 1'b1;
    symData  = v;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      symValid = 1'b0;
      symData  = 4'd0;
    end
  endtask

  task automatic sendOctet(input logic [7:0] b, input bit gap);
    sendSym(b[3:0], gap);
    sendSym(b[7:4], gap);
  endtask

  task automatic sendFrame(input int nz, input int len, input bit resv, input bit gap);
    for (int k = 0; k < nz; k++) sendSym(4'h0, gap);
    sendSym(4'h7, gap);
    sendSym(4'hA, gap);
    @(posedge clk); #1;
    check(frameStart === 1'b1, "R2 start pulse after delimiter", int'(frameStart), 1);
    sendOctet({resv, 7'(len)}, gap);
    if (!resv)
      for (int i = 0; i < len; i++) sendOctet(pat(len, i), gap);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int s0, d0, e0, w0, bad;
    repeat (3) @(negedge clk);
    check(frameStart == 0 && bufWe == 0 && frameDone == 0 && fmtErr == 0,
          "R5 reset outputs idle", int'({frameStart, bufWe, frameDone, fmtErr}), 0);
    check(frameLen == 0, "R4 reset length", int'(frameLen), 0);
    rstN = 1'b1;
    idle(2);

    // R4 R3 R8 R6 R7: sweep every length
    for (int len = 0; len < 128; len++) begin
      s0 = nStart; d0 = nDone; e0 = nErr; w0 = nWr;
      for (int i = 0; i < 128; i++) mem[i] = 8'hxx;
      sendFrame(2 + len % 3, len, 1'b0, (len % 5) == 0);
      if (len == 0) begin
        @(posedge clk); #1;
        check(frameDone === 1'b1, "R6 done right after zero-length header", int'(frameDone), 1);
      end
      idle(3);
      check(nStart - s0 == 1, "R1 frame started", nStart - s0, 1);
      check(nDone - d0 == 1, "R7 one done pulse", nDone - d0, 1);
      check(nErr - e0 == 0, "R5 no error on clean header", nErr - e0, 0);
      check(nWr - w0 == len, "R4 write count equals length", nWr - w0, len);
      check(frameLen == 7'(len), "R4 decoded length", int'(frameLen), len);
      bad = 0;
      for (int i = 0; i < len; i++) if (mem[i] !== pat(len, i)) bad++;
      check(bad == 0, "R3 R8 payload octets at addresses", bad, 0);
    end

    // R1: one zero only
    s0 = nStart;
    sendSym(4'h0, 0); sendSym(4'h7, 0); sendSym(4'hA, 0); idle(3);
    check(nStart == s0, "R1 single zero rejected", nStart - s0, 0);

    // R2: stray symbol between preamble and delimiter
    sendSym(4'h0, 0); sendSym(4'h0, 0); sendSym(4'h5, 0);
    sendSym(4'h7, 0); sendSym(4'hA, 0); idle(3);
    check(nStart == s0, "R2 stray symbol resets search", nStart - s0, 0);

    // R2: wrong second delimiter nibble
    sendSym(4'h0, 0); sendSym(4'h0, 0); sendSym(4'h7, 0);
    sendSym(4'h3, 0); sendSym(4'hA, 0); idle(3);
    check(nStart == s0, "R2 wrong high nibble rejected", nStart - s0, 0);

    // R9: invalid cycles carry junk between preamble zeros
    d0 = nDone; w0 = nWr;
    sendSym(4'h0, 1); sendSym(4'h0, 1);
    sendSym(4'h7, 1); sendSym(4'hA, 1);
    sendOctet(8'h04, 1);
    for (int i = 0; i < 4; i++) sendOctet(pat(4, i), 1);
    idle(3);
    check(nStart - s0 == 1, "R9 invalid cycles ignored in search", nStart - s0, 1);
    check(nDone - d0 == 1 && nWr - w0 == 4, "R9 frame completes with gaps",
          nWr - w0, 4);

    // R5: reserved bit set
    s0 = nStart; d0 = nDone; e0 = nErr; w0 = nWr;
    sendFrame(3, 5, 1'b1, 1'b0);
    @(posedge clk); #1;
    check(fmtErr === 1'b1, "R5 error pulse after header", int'(fmtErr), 1);
    idle(3);
    check(nErr - e0 == 1, "R5 one error pulse", nErr - e0, 1);
    check(nDone == d0 && nWr == w0, "R5 no writes or done", nWr - w0, 0);
    sendFrame(2, 6, 1'b0, 1'b0);
    idle(3);
    check(nDone - d0 == 1 && nWr - w0 == 6, "R5 search resumes after error", nWr - w0, 6);

    // R7: back-to-back frames
    d0 = nDone; w0 = nWr;
    sendFrame(2, 3, 1'b0, 1'b0);
    sendFrame(2, 9, 1'b0, 1'b0);
    idle(3);
    check(nDone - d0 == 2, "R7 back-to-back frames complete", nDone - d0, 2);
    check(nWr - w0 == 12, "R7 back-to-back write total", nWr - w0, 12);
    bad = 0;
    for (int i = 0; i < 9; i++) if (mem[i] !== pat(9, i)) bad++;
    check(bad == 0, "R3 second frame content", bad, 0);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule